// File: doc/BRIEF.md
# Latched Three-Digit BCD Event Counter with Scanned Output

This block counts events on a single input line and shows the total as three decimal digits. Each falling edge of the event input, seen in the system clock domain, adds one to a three-decade BCD count. The count runs from 000 to 999 and then wraps. Every decade steps on the same clock edge, so a carry never ripples through a chain of stages. A separate clear input forces the count to zero at any time.

Next to the count sits a bank of digit latches. While the latch enable is high, the latches copy the live count. While it is low, they hold their value. This gives two ways to use the block. Tie the enable high to watch events pile up. Or pulse the enable just before each clear, so that every fixed gate interval shows one reading, which is how a frequency measurement is made.

A scan divider steps through the three latched digits in turn, least significant first. At each step the block puts that digit on a shared four-bit bus and pulls the matching active-low digit select low. An external BCD to seven-segment decoder can then refresh a multiplexed display. The dwell time per digit is one third of the refresh period. That period comes from the system clock frequency and a chosen refresh rate, which must lie in the flicker-free band of about 200 Hz to 1 kHz; the default is 500 Hz.

Top module: `bcd_scan_counter`

## Requirements
- R1: Each high-to-low transition of `count_in` adds exactly one to the count. The count is held as three BCD digits, each taking only the codes 0 to 9 (4'd0 to 4'd9).
- R2: A digit that advances past 9 returns to 0, and the next more significant digit advances on the same clock edge (for example 099 becomes 100 after one event).
- R3: The event after 999 gives 000. `ovf` is high for exactly one clock cycle at that wrap and stays low at all other times.
- R4: While `latch_en` is high, the latched digits follow the live count one clock later, so the scanned output shows the current count.
- R5: While `latch_en` is low, the latched digits and the scanned value do not change, however many events arrive.
- R6: Raising `cnt_clr` clears the count to 000 at once, without waiting for a clock, and also clears `ovf`. The latched digits keep their value, so a reading captured before the clear is still displayed.
- R7: `dsel_n` has at most one bit low. Bit 0 selects the least significant digit, bit 1 the middle digit and bit 2 the most significant digit. They are selected in the order 3'b110, 3'b101, 3'b011 and then repeat. Each is held for DIGIT_TICKS = CLK_HZ / (3 * REFRESH_HZ) clock cycles.
- R8: `bcd_out` and `dsel_n` change on the same clock edge. `bcd_out` always carries the latched value of the digit whose select is low.
- R9: While `rst_n` is low, `dsel_n` is 3'b111, `bcd_out` is 0 and `ovf` is 0. After reset the count and the latched digits read 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| count_in | input | 1 | Event input; each falling edge counts once |
| cnt_clr | input | 1 | Asynchronous active-high clear of the count and `ovf` |
| latch_en | input | 1 | High: latches follow the count; low: latches hold |
| bcd_out | output | 4 | BCD code of the currently selected digit |
| dsel_n | output | 3 | Active-low one-hot digit select, bit 0 = least significant digit |
| ovf | output | 1 | One-cycle pulse when the count wraps from 999 to 000 |

## Verification
A decade holding a wrong code, or a carry taken on the wrong edge, shows up as a wrong digit on `bcd_out`. This happens within one full scan of 3*DIGIT_TICKS cycles after the latches next copy the count. A latch that fails to hold, or fails to follow, shows up in the same way, because the displayed value drifts from the count that was captured. A fault in the scan counter or the digit index shows at once at the ports: a select held for the wrong length, the wrong digit order, or a bus value that does not match the digit selected.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int NUM_DIGITS = 3;
  localparam int BCD_W      = 4;

  typedef logic [BCD_W-1:0]       bcd_t;
  typedef bcd_t [NUM_DIGITS-1:0]  bcd_vec_t;

  localparam bcd_t BCD_MAX = 4'd9;
endpackage

// File: rtl/bsc_fall_sync.sv
module bsc_fall_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall_pulse
);
  localparam int SW = STAGES + 1;

  logic [SW-1:0] shift_q;
  logic [SW-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[SW-2:0], async_in};
  end

  // idle level of the event line is high, so reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '1;
    else        shift_q <= shift_d;
  end

  assign fall_pulse = shift_q[SW-1] & ~shift_q[SW-2];
endmodule

// File: rtl/bsc_decade_chain.sv
module bsc_decade_chain
  import bsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     inc,
  output bcd_vec_t digits,
  output logic     wrap
);
  logic [NUM_DIGITS-1:0] step_en;
  bcd_vec_t              dig_q;
  bcd_vec_t              dig_d;
  logic                  wrap_q;
  logic                  wrap_d;

  // carries are decoded from present state: every decade steps on one edge
  assign step_en[0] = inc;

  genvar g;
  generate
    for (g = 1; g < NUM_DIGITS; g++) begin : g_carry
      assign step_en[g] = step_en[g-1] && (dig_q[g-1] == BCD_MAX);
    end

    for (g = 0; g < NUM_DIGITS; g++) begin : g_decade
      always_comb begin
        dig_d[g] = dig_q[g];
        if (step_en[g]) begin
          dig_d[g] = (dig_q[g] == BCD_MAX) ? bcd_t'(0) : dig_q[g] + bcd_t'(1);
        end
      end

      always_ff @(posedge clk or negedge rst_n or posedge clr) begin
        if (!rst_n)   dig_q[g] <= '0;
        else if (clr) dig_q[g] <= '0;
        else          dig_q[g] <= dig_d[g];
      end

      // R1
      digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dig_q[g] <= BCD_MAX);
    end
  endgenerate

  assign wrap_d = step_en[NUM_DIGITS-1] && (dig_q[NUM_DIGITS-1] == BCD_MAX);

  always_ff @(posedge clk or negedge rst_n or posedge clr) begin
    if (!rst_n)   wrap_q <= 1'b0;
    else if (clr) wrap_q <= 1'b0;
    else          wrap_q <= wrap_d;
  end

  assign digits = dig_q;
  assign wrap   = wrap_q;

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_q |-> (dig_q == '0));

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (dig_q == '0 && !wrap_q));
endmodule

// File: rtl/bsc_digit_latch.sv
module bsc_digit_latch
  import bsc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  bcd_vec_t live,
  output bcd_vec_t held
);
  bcd_vec_t held_q;
  bcd_vec_t held_d;

  always_comb begin
    held_d = held_q;
    if (load) held_d = live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign held = held_q;

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(held_q));

  // R4
  latch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (held_q == $past(live)));
endmodule

// File: rtl/bsc_scan_mux.sv
module bsc_scan_mux
  import bsc_pkg::*;
#(
  parameter int DIGIT_TICKS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  bcd_vec_t              held,
  output bcd_t                  bcd_out,
  output logic [NUM_DIGITS-1:0] dsel_n
);
  localparam int TW = (DIGIT_TICKS > 1) ? $clog2(DIGIT_TICKS) : 1;
  localparam int IW = $clog2(NUM_DIGITS);
  localparam logic [TW-1:0] TICK_LAST = TW'(DIGIT_TICKS - 1);
  localparam logic [IW-1:0] IDX_LAST  = IW'(NUM_DIGITS - 1);

  logic [TW-1:0]         tick_q, tick_d;
  logic [IW-1:0]         idx_q, idx_d;
  logic                  tick_wrap;
  bcd_t                  bcd_q, bcd_d;
  logic [NUM_DIGITS-1:0] sel_q, sel_d;

  assign tick_wrap = (tick_q == TICK_LAST);

  always_comb begin
    tick_d = tick_wrap ? '0 : tick_q + TW'(1);
    idx_d  = idx_q;
    if (tick_wrap) idx_d = (idx_q == IDX_LAST) ? '0 : idx_q + IW'(1);
  end

  // bus and strobe come from the same index through one register stage
  always_comb begin
    bcd_d = held[idx_q];
    sel_d = ~(NUM_DIGITS'(1) << idx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      idx_q  <= '0;
      bcd_q  <= '0;
      sel_q  <= '1;
    end else begin
      tick_q <= tick_d;
      idx_q  <= idx_d;
      bcd_q  <= bcd_d;
      sel_q  <= sel_d;
    end
  end

  assign bcd_out = bcd_q;
  assign dsel_n  = sel_q;

  // assertion support: cycles since the last strobe change
  int unsigned dwell_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                dwell_q <= 0;
    else if (sel_q != sel_d)   dwell_q <= 0;
    else                       dwell_q <= dwell_q + 1;
  end

  // R7
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sel_q));

  // R7
  scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != sel_d && sel_q != '1) |-> (sel_d == {sel_q[NUM_DIGITS-2:0], sel_q[NUM_DIGITS-1]}));

  // R7
  dwell_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != sel_d && sel_q != '1) |-> (dwell_q == DIGIT_TICKS - 1));

  genvar g;
  generate
    for (g = 0; g < NUM_DIGITS; g++) begin : g_bus_chk
      // R8
      bus_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q[g] |-> (bcd_q == $past(held[g])));
    end
  endgenerate
endmodule

// File: rtl/bcd_scan_counter.sv
module bcd_scan_counter
  import bsc_pkg::*;
#(
  parameter int CLK_HZ     = 125_000_000,
  parameter int REFRESH_HZ = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       count_in,
  input  logic       cnt_clr,
  input  logic       latch_en,
  output logic [3:0] bcd_out,
  output logic [2:0] dsel_n,
  output logic       ovf
);
  localparam int DIGIT_TICKS = CLK_HZ / (NUM_DIGITS * REFRESH_HZ);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       ev_fall;
  bcd_vec_t   live_dig;
  bcd_vec_t   held_dig;
  bcd_t       bus_q;
  logic [NUM_DIGITS-1:0] sel_n;
  logic       wrap_p;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  bsc_fall_sync #(.STAGES(2)) u_fall (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .async_in   (count_in),
    .fall_pulse (ev_fall)
  );

  bsc_decade_chain u_chain (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (cnt_clr),
    .inc    (ev_fall),
    .digits (live_dig),
    .wrap   (wrap_p)
  );

  bsc_digit_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (latch_en),
    .live  (live_dig),
    .held  (held_dig)
  );

  bsc_scan_mux #(.DIGIT_TICKS(DIGIT_TICKS)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .held    (held_dig),
    .bcd_out (bus_q),
    .dsel_n  (sel_n)
  );

  assign bcd_out = bus_q;
  assign dsel_n  = sel_n;
  assign ovf     = wrap_p;

  // R3
  ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ovf |=> !ovf);
endmodule

// File: tb/bcd_scan_counter_tb.sv
module bcd_scan_counter_tb_top;
  localparam int T_CLK_HZ  = 1200;
  localparam int T_REF_HZ  = 100;
  localparam int T_TICKS   = T_CLK_HZ / (3 * T_REF_HZ);

  logic       clk = 1'b0;
  logic       rst_n;
  logic       count_in;
  logic       cnt_clr;
  logic       latch_en;
  logic [3:0] bcd_out;
  logic [2:0] dsel_n;
  logic       ovf;

  int checks = 0;
  int fails  = 0;
  int ovf_cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bcd_scan_counter #(.CLK_HZ(T_CLK_HZ), .REFRESH_HZ(T_REF_HZ)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_in (count_in),
    .cnt_clr  (cnt_clr),
    .latch_en (latch_en),
    .bcd_out  (bcd_out),
    .dsel_n   (dsel_n),
    .ovf      (ovf)
  );

  always @(negedge clk) if (ovf === 1'b1) ovf_cycles++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_events(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) count_in = 1'b0;
      repeat (2) @(negedge clk);
      count_in = 1'b1;
      repeat (2) @(negedge clk);
    end
  endtask

  // scan the display for more than one refresh, check the bus against the
  // expected digit each cycle, then assemble the decimal reading
  task automatic check_display(input int exp, input string req);
    int dig[3];
    bit seen[3];
    bit bus_ok;
    int got;
    bus_ok = 1;
    for (int i = 0; i < 3; i++) begin dig[i] = 0; seen[i] = 0; end
    repeat (2) @(negedge clk);
    for (int c = 0; c < 4 * T_TICKS + 2; c++) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        if (dsel_n == ~(3'b001 << i)) begin
          dig[i] = int'(bcd_out);
          seen[i] = 1;
          if (int'(bcd_out) != (exp / (10 ** i)) % 10) bus_ok = 0;
        end
      end
    end
    got = dig[2] * 100 + dig[1] * 10 + dig[0];
    if (!(seen[0] && seen[1] && seen[2])) got = -1;
    check(got == exp && bus_ok, req, got, exp);
  endtask

  initial begin
    rst_n = 1'b0; count_in = 1'b1; cnt_clr = 1'b0; latch_en = 1'b0;
    repeat (5) @(negedge clk);
    // R9 reset state
    check(dsel_n == 3'b111, "R9 dsel_n", int'(dsel_n), 7);
    check(bcd_out == 4'd0, "R9 bcd_out", int'(bcd_out), 0);
    check(ovf == 1'b0, "R9 ovf", int'(ovf), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_display(0, "R9 display after reset");

    // R1 R2 R4: exhaustive sweep over the whole range with latch open
    latch_en = 1'b1;
    for (int k = 1; k <= 1000; k++) begin
      pulse_events(1);
      if (k % 10 == 0) check_display(k % 1000, "R2 carry step");
      else             check_display(k % 1000, "R1 R4 count step");
      if (k == 999) check(ovf_cycles == 0, "R3 no early ovf", ovf_cycles, 0);
    end
    // R3 one-cycle pulse at wrap
    check(ovf_cycles == 1, "R3 ovf pulse width", ovf_cycles, 1);

    pulse_events(42);
    check_display(42, "R4 follow");

    // R5 hold with latch closed
    latch_en = 1'b0;
    pulse_events(7);
    check_display(42, "R5 hold");
    pulse_events(1);
    check_display(42, "R5 hold again");

    // R4 capture by a short enable pulse
    @(negedge clk) latch_en = 1'b1;
    @(negedge clk) latch_en = 1'b0;
    check_display(50, "R4 capture pulse");

    // R6 clear keeps latched reading
    @(negedge clk) cnt_clr = 1'b1;
    #1;
    check(ovf == 1'b0, "R6 ovf cleared", int'(ovf), 0);
    @(negedge clk) cnt_clr = 1'b0;
    check_display(50, "R6 latch kept across clear");
    @(negedge clk) latch_en = 1'b1;
    @(negedge clk) latch_en = 1'b0;
    check_display(0, "R6 count cleared");
    latch_en = 1'b1;
    pulse_events(3);
    check_display(3, "R6 count after clear");

    // R7 R8 scan order and dwell
    begin
      logic [2:0] prev;
      int run;
      int seg;
      bit first;
      prev = dsel_n; run = 0; seg = 0; first = 1;
      while (seg < 7) begin
        @(negedge clk);
        if (dsel_n == prev) run++;
        else begin
          if (!first) begin
            check(run + 1 == T_TICKS, "R7 dwell", run + 1, T_TICKS);
            check(dsel_n == {prev[1:0], prev[2]}, "R7 order",
                  int'(dsel_n), int'({prev[1:0], prev[2]}));
          end
          first = 0; prev = dsel_n; run = 0; seg++;
        end
      end
    end
    check_display(3, "R8 bus matches select");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule